// File: doc/BRIEF.md
# Polled Byte Bridge to an External USB FIFO

This block connects user logic inside the FPGA to an external USB FIFO device over one shared, tri-stated 8-bit data bus. The external device reports its state on two active-low status lines. One says a received byte is waiting. The other says there is room for a transmit byte. The bridge moves bytes with two strobes: an active-low read enable and an active-high write strobe. The device captures a written byte on the falling edge of that write strobe.

Toward the user logic the bridge offers two byte streams, each with a valid/ready handshake. The receive stream carries bytes from the external device. The transmit stream carries bytes toward it. The bridge first passes both status lines through synchronizers. It then chooses one direction at a time, alternating when both are ready, and runs each bus transaction as a sequence of timed phases. Between transactions it releases the bus and parks both strobes, so other devices may use the shared lines.

The pad itself lies outside the block. The bridge drives separate outgoing data and an output-enable signal, and it takes the incoming pad value on its own input. The bridge runs from a 50 MHz system clock. Each strobe phase lasts a parameter number of clocks, 4 by default.

Top module: `usb_fifo_bridge`

## Requirements
- R1: While reset is asserted and right after it, the read enable is high, the write strobe is low, the output enable is low and rx_valid is low.
- R2: Outside a transaction the output enable is low, the read enable is high and the write strobe is low.
- R3: A write begins only after the synchronized transmit-space status has been seen low while the user offers a byte. tx_ready is high for the single cycle in which that byte is accepted.
- R4: A write proceeds in fixed steps. The output enable rises together with the write strobe. The strobe stays high for PHASE_CYC cycles and then low for PHASE_CYC cycles, with the output enable still high and bus_out unchanged. Only after that is the bus released. The data is therefore stable across the falling edge.
- R5: A read begins only when the synchronized receive-available status is low and the receive hold register is either empty or being emptied in that same cycle.
- R6: The output enable is never high while the read enable is low.
- R7: After every transaction the bridge holds the bus released, with both strobes inactive, for SYNC_STAGES+1 cycles before it starts another.
- R8: When both directions are eligible in the same cycle, the bridge serves the direction that the most recent transaction did not serve. The first transaction after reset counts as following a write, so a receive wins it.
- R9: During a read the read enable stays low for exactly PHASE_CYC cycles. bus_in is sampled in the last of those cycles. The bytes appear on rx_data in the order the external device supplied them.
- R10: Bytes accepted on the transmit stream are written to the bus in the order they were accepted.
- R11: Once rx_valid is high, it and rx_data stay unchanged until a cycle with rx_ready high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_rxf_n | input | 1 | External device has a byte to read (active low, asynchronous) |
| ext_txe_n | input | 1 | External device can take a byte (active low, asynchronous) |
| ext_rd_n | output | 1 | Read enable to the external device (active low) |
| ext_wr | output | 1 | Write strobe to the external device (data captured on its falling edge) |
| bus_in | input | DATA_W | Value seen on the shared bus pads |
| bus_out | output | DATA_W | Value driven onto the shared bus when enabled |
| bus_oe | output | 1 | Output enable for the bus pad drivers |
| rx_data | output | DATA_W | Received byte toward user logic |
| rx_valid | output | 1 | rx_data holds a byte |
| rx_ready | input | 1 | User logic takes the byte this cycle |
| tx_data | input | DATA_W | Byte from user logic to transmit |
| tx_valid | input | 1 | tx_data holds a byte to send |
| tx_ready | output | 1 | The bridge accepts tx_data this cycle |

## Verification
The assertions rely on two assumptions about the external device. First, it releases a status line within one system clock after the strobe that ended a transaction. Second, it holds that status inactive for at least one clock afterwards. Together these ensure that a status value which the synchronizers flag as stale always lands inside the post-transaction gap. The bench models the device so that it meets both assumptions: it raises the receive status for one cycle after each read and the transmit status for one cycle after each write. It changes all external inputs half a clock away from the active edge. Under these conditions a byte is never read from an empty device and never written into a full one.

// File: rtl/ufb_pkg.sv
package ufb_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_RD    = 3'd1,
      ST_WR_HI = 3'd2,
      ST_WR_LO = 3'd3,
      ST_GAP   = 3'd4
   } ufb_state_e;

   function automatic int ufb_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ufb_sync.sv
module ufb_sync #(
   parameter int WIDTH     = 2,
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   if (STAGES < 2) begin : g_bad_stages
      $error("ufb_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ufb_sync: WIDTH must be at least 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
         end else begin
            chain <= {chain[STAGES-2:0], din[b]};
         end
      end

      assign dout[b] = chain[STAGES-1];
   end

endmodule

// File: rtl/ufb_rx_hold.sv
module ufb_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   output logic              can_accept
);

   if (DATA_W < 1) begin : g_bad_width
      $error("ufb_rx_hold: DATA_W must be at least 1");
   end

   assign can_accept = !rx_valid || rx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else if (load) begin
         rx_data  <= din;
         rx_valid <= 1'b1;
      end else if (rx_valid && rx_ready) begin
         rx_valid <= 1'b0;
      end
   end

   // R11: a waiting byte is held unchanged until it is taken
   a_r11_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

   // R5: the sequencer only loads when the byte can be stored
   a_r5_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (!rx_valid || rx_ready));

endmodule

// File: rtl/ufb_seq.sv
module ufb_seq
   import ufb_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int PHASE_CYC = 4,
   parameter int GAP_CYC   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rxf_s_n,
   input  logic              txe_s_n,
   input  logic              rx_can,
   input  logic              tx_valid,
   input  logic [DATA_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              rd_n_o,
   output logic              wr_o,
   output logic              oe_o,
   output logic [DATA_W-1:0] dout,
   output logic              cap_en
);

   localparam int CNT_MAX = ufb_max(PHASE_CYC, GAP_CYC);
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] PH_LAST  = CNT_W'(PHASE_CYC - 1);
   localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYC - 1);

   if (PHASE_CYC < 1) begin : g_bad_phase
      $error("ufb_seq: PHASE_CYC must be at least 1");
   end
   if (GAP_CYC < 1) begin : g_bad_gap
      $error("ufb_seq: GAP_CYC must be at least 1");
   end

   ufb_state_e       state;
   logic [CNT_W-1:0] cnt;
   logic             last_rx;
   logic             rx_ok, tx_ok, pick_tx, pick_rx, ph_done;

   always_comb begin
      rx_ok   = !rxf_s_n && rx_can;
      tx_ok   = !txe_s_n && tx_valid;
      pick_tx = tx_ok && (!rx_ok || last_rx);
      pick_rx = rx_ok && !pick_tx;
      ph_done = (cnt == PH_LAST);
   end

   assign tx_ready = (state == ST_IDLE) && pick_tx;
   assign rd_n_o   = (state != ST_RD);
   assign wr_o     = (state == ST_WR_HI);
   assign oe_o     = (state == ST_WR_HI) || (state == ST_WR_LO);
   assign cap_en   = (state == ST_RD) && ph_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         last_rx <= 1'b0;
         dout    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               cnt <= '0;
               if (pick_rx) begin
                  state   <= ST_RD;
                  last_rx <= 1'b1;
               end else if (pick_tx) begin
                  state   <= ST_WR_HI;
                  dout    <= tx_data;
                  last_rx <= 1'b0;
               end
            end
            ST_RD: begin
               if (ph_done) begin
                  state <= ST_GAP;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WR_HI: begin
               if (ph_done) begin
                  state <= ST_WR_LO;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_WR_LO: begin
               if (ph_done) begin
                  state <= ST_GAP;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_GAP: begin
               if (cnt == GAP_LAST) begin
                  state <= ST_IDLE;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= ST_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   // R3: a write strobe only rises after transmit space was seen
   a_r3_tx_after_status: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_o) |-> $past(!txe_s_n && tx_valid));

   // R5: a read only starts when data is waiting and can be stored
   a_r5_rx_after_status: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n_o) |-> $past(!rxf_s_n && rx_can));

   // R4: driven data does not move while the drivers are on
   a_r4_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_o && $past(oe_o)) |-> $stable(dout));

   // R7: a transaction starts only from a released, quiet bus
   a_r7_quiet_before_start: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n_o) || $rose(oe_o)) |-> $past(rd_n_o && !oe_o && !wr_o));

endmodule

// File: rtl/usb_fifo_bridge.sv
module usb_fifo_bridge #(
   parameter int DATA_W      = 8,
   parameter int PHASE_CYC   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_rxf_n,
   input  logic              ext_txe_n,
   output logic              ext_rd_n,
   output logic              ext_wr,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_valid,
   input  logic              rx_ready,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready
);

   localparam int GAP_CYC = SYNC_STAGES + 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("usb_fifo_bridge: DATA_W must be at least 1");
   end

   logic [1:0] stat_s;
   logic       rx_can, cap_en;

   ufb_sync #(
      .WIDTH     (2),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({ext_txe_n, ext_rxf_n}),
      .dout  (stat_s)
   );

   ufb_seq #(
      .DATA_W    (DATA_W),
      .PHASE_CYC (PHASE_CYC),
      .GAP_CYC   (GAP_CYC)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rxf_s_n  (stat_s[0]),
      .txe_s_n  (stat_s[1]),
      .rx_can   (rx_can),
      .tx_valid (tx_valid),
      .tx_data  (tx_data),
      .tx_ready (tx_ready),
      .rd_n_o   (ext_rd_n),
      .wr_o     (ext_wr),
      .oe_o     (bus_oe),
      .dout     (bus_out),
      .cap_en   (cap_en)
   );

   ufb_rx_hold #(
      .DATA_W (DATA_W)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cap_en),
      .din        (bus_in),
      .rx_data    (rx_data),
      .rx_valid   (rx_valid),
      .rx_ready   (rx_ready),
      .can_accept (rx_can)
   );

endmodule

// File: tb/usb_fifo_bridge_tb.sv
module usb_fifo_bridge_tb;

   localparam int PH = 4;
   localparam int SS = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_rxf_n = 1'b1, ext_txe_n = 1'b1;
   logic       ext_rd_n, ext_wr, bus_oe;
   logic [7:0] bus_in = 8'h00, bus_out;
   logic [7:0] rx_data, tx_data = 8'h00;
   logic       rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;

   usb_fifo_bridge #(.DATA_W(8), .PHASE_CYC(PH), .SYNC_STAGES(SS)) u_dut (
      .clk(clk), .rst_n(rst_n), .ext_rxf_n(ext_rxf_n), .ext_txe_n(ext_txe_n),
      .ext_rd_n(ext_rd_n), .ext_wr(ext_wr), .bus_in(bus_in), .bus_out(bus_out),
      .bus_oe(bus_oe), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
      .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
   );

   always #5 clk = ~clk;

   int n_tests = 0, n_fail = 0;
   logic [7:0] host_q[$];
   logic [7:0] rx_exp[$];
   logic [7:0] tx_src[$];
   logic [7:0] tx_exp[$];
   bit  tx_block = 1'b1, rx_ready_en = 1'b1, sat = 1'b0, arm = 1'b0;
   int  armed_type = -1, last_type = -1;
   int  rd_starts = 0, wr_starts = 0, tx_fires = 0;
   int  rd_len = 0, wh_len = 0, wl_len = 0;
   bit  rxf_hold = 1'b0, txe_hold = 1'b0;
   logic p_rd_n = 1'b1, p_wr = 1'b0, p_oe = 1'b0, p_rxv = 1'b0, p_fire = 1'b0;
   logic [7:0] p_out = 8'h00, p_rxd = 8'h00;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic note_start(input int t);
      if (arm) begin
         armed_type = t;
         arm = 1'b0;
      end
      if (sat && host_q.size() > 1 && tx_src.size() > 1)
         chk(last_type != t, "R8", "alternation under load", t, 1 - t);
      last_type = t;
   endtask

   // external device model and per-cycle protocol checks
   always begin
      @(negedge clk);
      if (rst_n) begin
         if (bus_oe && !ext_rd_n) chk(1'b0, "R6", "drivers on during read", 1, 0);
         if (ext_wr && !bus_oe)   chk(1'b0, "R4", "strobe without drivers", 1, 0);
         if (bus_oe && p_oe && bus_out != p_out)
            chk(1'b0, "R4", "bus_out moved while driven", bus_out, p_out);
         if (!ext_rd_n && p_rd_n) begin
            chk(!p_oe && !p_wr, "R7", "quiet cycle before read", p_oe, 0);
            rd_starts++;
            rd_len = 0;
            note_start(0);
         end
         if (bus_oe && !p_oe) begin
            chk(p_rd_n && ext_wr, "R7", "quiet cycle before write", p_rd_n, 1);
            wr_starts++;
            wh_len = 0;
            wl_len = 0;
            note_start(1);
         end
         if (!ext_rd_n) rd_len++;
         if (ext_rd_n && !p_rd_n) begin
            chk(rd_len == PH, "R9", "read enable low length", rd_len, PH);
            if (host_q.size() > 0) void'(host_q.pop_front());
            rxf_hold = 1'b1;
         end
         if (ext_wr) wh_len++;
         if (bus_oe && !ext_wr) wl_len++;
         if (!ext_wr && p_wr) begin
            chk(wh_len == PH, "R4", "write strobe high length", wh_len, PH);
            chk(bus_oe == 1'b1, "R4", "drivers on at falling edge", bus_oe, 1);
            if (tx_exp.size() > 0) begin
               logic [7:0] e;
               e = tx_exp.pop_front();
               chk(p_out == e, "R10", "byte written to device", p_out, e);
            end else chk(1'b0, "R10", "unexpected write", p_out, 0);
            txe_hold = 1'b1;
         end
         if (!bus_oe && p_oe)
            chk(wl_len == PH, "R4", "write strobe low length", wl_len, PH);
         if (p_rxv && !p_fire)
            chk(rx_valid && rx_data == p_rxd, "R11", "held byte", rx_data, p_rxd);
      end
      ext_rxf_n = (host_q.size() == 0) || rxf_hold;
      rxf_hold  = 1'b0;
      ext_txe_n = tx_block || txe_hold;
      txe_hold  = 1'b0;
      bus_in    = (!ext_rd_n && host_q.size() > 0) ? host_q[0] : 8'h00;
      tx_valid  = (tx_src.size() > 0);
      tx_data   = (tx_src.size() > 0) ? tx_src[0] : 8'h00;
      rx_ready  = rx_ready_en;
      p_rd_n = ext_rd_n; p_wr = ext_wr; p_oe = bus_oe; p_out = bus_out;
      #1;
      p_rxv  = rx_valid;
      p_rxd  = rx_data;
      p_fire = rst_n && rx_valid && rx_ready;
      if (p_fire) begin
         if (rx_exp.size() > 0) begin
            logic [7:0] e;
            e = rx_exp.pop_front();
            chk(rx_data == e, "R9", "received byte order", rx_data, e);
         end else chk(1'b0, "R9", "unexpected received byte", rx_data, 0);
      end
      if (rst_n && tx_valid && tx_ready) begin
         tx_fires++;
         tx_exp.push_back(tx_src.pop_front());
      end
   end

   task automatic push_host(input int n, input int seed);
      for (int i = 0; i < n; i++) begin
         logic [7:0] b;
         b = 8'(seed + i * 37 + 5);
         host_q.push_back(b);
         rx_exp.push_back(b);
      end
   endtask

   task automatic push_tx(input int n, input int seed);
      for (int i = 0; i < n; i++) tx_src.push_back(8'(seed * 3 + i * 71 + 1));
   endtask

   task automatic drain();
      int w;
      w = 0;
      while ((host_q.size() || rx_exp.size() || tx_src.size() || tx_exp.size() ||
              rx_valid || !ext_rd_n || bus_oe) && w < 3000) begin
         @(negedge clk);
         w++;
      end
      @(negedge clk);
      chk(rx_exp.size() == 0, "R9", "all bytes received", rx_exp.size(), 0);
      chk(tx_exp.size() == 0 && tx_src.size() == 0, "R10", "all bytes written",
          tx_exp.size() + tx_src.size(), 0);
      chk(ext_rd_n && !ext_wr && !bus_oe, "R2", "bus released when idle",
          {ext_rd_n, ext_wr, bus_oe}, 3'b100);
   endtask

   task automatic race(input int exp, input string what);
      tx_block = 1'b1;
      push_tx(2, 40 + exp);
      repeat (8) @(negedge clk);
      armed_type = -1;
      push_host(2, 90 + exp);
      tx_block = 1'b0;
      arm = 1'b1;
      for (int i = 0; i < 200 && armed_type < 0; i++) @(negedge clk);
      chk(armed_type == exp, "R8", what, armed_type, exp);
      drain();
   endtask

   initial begin
      int r0, w0, f0;
      repeat (3) @(negedge clk);
      chk(ext_rd_n && !ext_wr && !bus_oe && !rx_valid, "R1", "state in reset",
          {ext_rd_n, ext_wr, bus_oe, rx_valid}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ext_rd_n && !ext_wr && !bus_oe && !rx_valid && !tx_ready, "R1",
          "state after reset", {ext_rd_n, ext_wr, bus_oe, rx_valid}, 4'b1000);

      // R8: first contest after reset goes to receive
      race(0, "first grant after reset");
      // R8: after a read the write wins
      tx_block = 1'b1;
      push_host(1, 7);
      drain();
      race(1, "grant after a read");
      // R8: after a write the read wins
      tx_block = 1'b0;
      push_tx(1, 9);
      drain();
      race(0, "grant after a write");

      // R3: no write while the device reports no space
      tx_block = 1'b1;
      w0 = wr_starts; f0 = tx_fires;
      push_tx(1, 55);
      repeat (60) @(negedge clk);
      chk(wr_starts == w0, "R3", "no write while full", wr_starts - w0, 0);
      chk(tx_fires == f0, "R3", "byte not accepted while full", tx_fires - f0, 0);
      tx_block = 1'b0;
      drain();

      // R5: no read with nothing waiting
      r0 = rd_starts;
      repeat (40) @(negedge clk);
      chk(rd_starts == r0, "R5", "no read from empty device", rd_starts - r0, 0);

      // R5 and R11: full hold register blocks further reads
      rx_ready_en = 1'b0;
      r0 = rd_starts;
      push_host(3, 120);
      repeat (80) @(negedge clk);
      chk(rd_starts - r0 == 1, "R5", "single read while hold full", rd_starts - r0, 1);
      chk(rx_valid == 1'b1, "R11", "byte still offered", rx_valid, 1);
      rx_ready_en = 1'b1;
      drain();

      // R8, R9, R10: both streams saturated
      sat = 1'b1;
      push_host(20, 200);
      push_tx(20, 77);
      drain();
      sat = 1'b0;

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R2", "watchdog expired", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule